// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers thirty-two level-sensitive interrupt lines from peripherals and fans them onto eight CPU interrupt lines. Software enables each source with one bit of a mask word and steers it to a CPU line through a 4-bit routing field. A CPU line is high for as long as at least one source that is enabled, currently high and routed to that line stays high. Nothing is latched: the handler clears the cause at the peripheral, and the CPU line falls on its own.

Registers are reached through a plain 32-bit port with word addresses. A write takes effect on the clock edge that samples it. Read data is combinational from the address. The source lines pass through a two-flop synchroniser before they reach the status word and the routing logic. The CPU lines come from flops.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the mask word and all four routing words read 0 and all eight CPU lines are low.
- R2: Word address 0 is the mask, readable and writable; bit n enables source n.
- R3: Word address 1 reads the synchronised state of the 32 source lines. A change at the inputs is visible there two clocks later. Writes to this address change no register.
- R4: Word addresses 2 to 5 are routing words that read back exactly what was written. Address 5 holds sources 0 to 7, address 4 holds 8 to 15, address 3 holds 16 to 23 and address 2 holds 24 to 31. Source n sits in bits [(n mod 8)*4 +: 4] of its word.
- R5: The CPU line of a source is the low three bits of its routing field. Bit 3 of the field is stored but does not affect routing, so field values 8 to 15 select lines 0 to 7.
- R6: CPU line k is high exactly when some source n has its synchronised level high, its mask bit set and its routing field selecting k. A line falls once its sources fall, with no latching.
- R7: A change at a source input reaches the CPU lines on the third rising edge after it. A write to the mask or to a routing word reaches the CPU lines on the edge after the write edge.
- R8: Word addresses 6 and 7 read 0, and writes to them change no register.
- R9: Writing 0 to the mask drives all CPU lines low one clock after the write edge, whatever the sources do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_irq | input | 32 | Level interrupt lines from peripherals |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cpu_irq | output | 8 | CPU interrupt lines |

## Verification
A source edge is due at the status word two clocks after it is driven and at the CPU lines three clocks after. A mask or routing write is due at the CPU lines one clock after the write edge. The bench drives inputs on falling edges and reads outputs at the falling edge where each result is due. The latency checks also read the edge just before, where the old value must still show. The sweeps let every output settle before they compare it with a model that the bench computes from the mask, the source levels and its own copy of the routing fields.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Word addresses of the register port
  localparam int unsigned WADDR_MASK   = 0;
  localparam int unsigned WADDR_STATUS = 1;
  localparam int unsigned WADDR_ROUTE0 = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      stage_q <= '0;
    end else begin
      meta_q  <= async_in;
      stage_q <= meta_q;
    end
  end

  assign sync_out = stage_q;
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [NUM_SRC-1:0]         status,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [NUM_SRC-1:0]         mask_q,
  output logic [NUM_SRC*FIELD_W-1:0] route_flat
);
  localparam int unsigned SRC_PER_WORD = DATA_W / FIELD_W;
  localparam int unsigned NUM_RW       = NUM_SRC / SRC_PER_WORD;
  localparam int unsigned LAST_WADDR   = WADDR_ROUTE0 + NUM_RW - 1;

  logic [NUM_SRC-1:0]             mask_d;
  logic                           mask_we;
  logic [NUM_RW-1:0][DATA_W-1:0]  words_all;

  // Mask word: clock enable, next state, register
  assign mask_we = bus_wr && (bus_addr == ADDR_W'(WADDR_MASK));

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = bus_wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // Routing words: word w serves source group NUM_RW-1-w (reversed packing)
  for (genvar w = 0; w < NUM_RW; w++) begin : g_route
    localparam int unsigned GRP = NUM_RW - 1 - w;
    logic              word_we;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    assign word_we = bus_wr && (bus_addr == ADDR_W'(WADDR_ROUTE0 + w));

    always_comb begin
      word_d = word_q;
      if (word_we) word_d = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign route_flat[GRP*DATA_W +: DATA_W] = word_q;
    assign words_all[w] = word_q;
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(WADDR_MASK)) begin
      bus_rdata = DATA_W'(mask_q);
    end else if (bus_addr == ADDR_W'(WADDR_STATUS)) begin
      bus_rdata = DATA_W'(status);
    end else begin
      for (int w = 0; w < int'(NUM_RW); w++) begin
        if (bus_addr == ADDR_W'(int'(WADDR_ROUTE0) + w)) bus_rdata = words_all[w];
      end
    end
  end

  AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(WADDR_STATUS)) |=> ($stable(mask_q) && $stable(route_flat))); // R3

  AST_LOW_GROUP_IN_TOP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(LAST_WADDR)) |=> (route_flat[DATA_W-1:0] == $past(bus_wdata))); // R4

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(LAST_WADDR)) |-> (bus_rdata == '0)); // R8

  AST_UNMAPPED_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr > ADDR_W'(LAST_WADDR)) |=> ($stable(mask_q) && $stable(route_flat))); // R8
endmodule

// File: rtl/irq_fanin.sv
module irq_fanin #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned FIELD_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         status,
  input  logic [NUM_SRC-1:0]         mask_q,
  input  logic [NUM_SRC*FIELD_W-1:0] route_flat,
  output logic [NUM_CPU-1:0]         cpu_irq
);
  localparam int unsigned SEL_W = $clog2(NUM_CPU);

  logic [NUM_SRC-1:0] pending;
  logic [NUM_CPU-1:0] irq_d;
  logic [NUM_CPU-1:0] irq_q;
  logic               unused_field_hi;

  assign pending = status & mask_q;

  // Only the low SEL_W bits of each field steer; the rest is kept for readback
  assign unused_field_hi = ^route_flat;

  always_comb begin
    irq_d = '0;
    for (int n = 0; n < int'(NUM_SRC); n++) begin
      if (pending[n]) irq_d[route_flat[n*FIELD_W +: SEL_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign cpu_irq = irq_q;

  AST_NO_PENDING_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |=> (cpu_irq == '0)); // R6

  AST_MASK_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> (cpu_irq == '0)); // R9

  AST_LINES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(cpu_irq) <= $countones($past(pending)))); // R6
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CPU = 8,
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_CPU-1:0] cpu_irq
);
  logic                       rst_meta_n;
  logic                       rst_sync_n;
  logic [NUM_SRC-1:0]         status;
  logic [NUM_SRC-1:0]         mask_q;
  logic [NUM_SRC*FIELD_W-1:0] route_flat;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  irq_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (src_irq),
    .sync_out (status)
  );

  irq_regfile #(
    .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .status     (status),
    .bus_rdata  (bus_rdata),
    .mask_q     (mask_q),
    .route_flat (route_flat)
  );

  irq_fanin #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .FIELD_W(FIELD_W)
  ) u_fanin (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .status     (status),
    .mask_q     (mask_q),
    .route_flat (route_flat),
    .cpu_irq    (cpu_irq)
  );
endmodule

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
  localparam int NS = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_m;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  cpu_irq;

  logic [3:0]  fld [NS];
  logic [31:0] mask_m;
  int          errs = 0;
  int          checks = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  irq_route_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_m), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_out();
    logic [7:0] o = '0;
    for (int n = 0; n < NS; n++)
      if (src_m[n] && mask_m[n]) o[fld[n][2:0]] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] route_word(input int w);
    logic [31:0] v = '0;
    int g = 5 - w;
    for (int j = 0; j < 8; j++) v[j*4 +: 4] = fld[g*8 + j];
    return v;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_routes();
    for (int w = 2; w <= 5; w++) wr(3'(w), route_word(w));
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] seed;
    rst_n = 1'b0; src_m = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    mask_m = '0;
    for (int n = 0; n < NS; n++) fld[n] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(3'd0, d); chk("R1 mask after reset", d, 32'h0);
    for (int w = 2; w <= 5; w++) begin
      rd(3'(w), d); chk("R1 route word after reset", d, 32'h0);
    end
    chk("R1 cpu lines after reset", 32'(cpu_irq), 32'h0);

    // R3 status tracks synchronised inputs, two clocks late
    @(negedge clk);
    src_m = 32'hA5C3_0F81;
    idle(1);
    rd(3'd1, d); chk("R3 status one clock after input", d, 32'h0);
    idle(1);
    rd(3'd1, d); chk("R3 status two clocks after input", d, 32'hA5C3_0F81);
    chk("R9 lines low with zero mask", 32'(cpu_irq), 32'h0);

    // R3 writes to status ignored
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R3 status write leaves mask", d, 32'h0);
    rd(3'd5, d); chk("R3 status write leaves routing", d, 32'h0);
    rd(3'd1, d); chk("R3 status still tracks inputs", d, 32'hA5C3_0F81);

    // R2 mask read/write
    mask_m = 32'h1234_5678;
    wr(3'd0, mask_m);
    rd(3'd0, d); chk("R2 mask readback", d, mask_m);

    // R4 routing readback and layout
    for (int n = 0; n < NS; n++) fld[n] = 4'((n*5 + 3) & 15);
    push_routes();
    for (int w = 2; w <= 5; w++) begin
      rd(3'(w), d); chk("R4 route word readback", d, route_word(w));
    end
    rd(3'd5, d); chk("R4 source 0 field at word 5 bits 3:0", 32'(d[3:0]), 32'(fld[0]));
    rd(3'd2, d); chk("R4 source 31 field at word 2 bits 31:28", 32'(d[31:28]), 32'(fld[31]));

    // R8 unmapped addresses
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hDEAD_BEEF);
    rd(3'd6, d); chk("R8 read addr 6", d, 32'h0);
    rd(3'd7, d); chk("R8 read addr 7", d, 32'h0);
    rd(3'd0, d); chk("R8 mask unchanged", d, mask_m);
    for (int w = 2; w <= 5; w++) begin
      rd(3'(w), d); chk("R8 routing unchanged", d, route_word(w));
    end

    // R6 combined output
    idle(2);
    chk("R6 lines for mixed pattern", 32'(cpu_irq), 32'(exp_out()));

    // R7 input-to-output latency
    mask_m = 32'h0; wr(3'd0, 32'h0);
    src_m = 32'h0;
    idle(4);
    mask_m = 32'h1; wr(3'd0, 32'h1);
    idle(3);
    chk("R7 idle before source", 32'(cpu_irq), 32'h0);
    @(negedge clk);
    src_m = 32'h1;
    idle(2);
    chk("R7 two clocks after source", 32'(cpu_irq), 32'h0);
    idle(1);
    chk("R7 three clocks after source", 32'(cpu_irq), 32'(8'(1) << fld[0][2:0]));

    // R7 / R9 mask write latency and clearing
    mask_m = 32'h0;
    wr(3'd0, 32'h0);
    chk("R7 line still set at write edge", 32'(cpu_irq), 32'(8'(1) << fld[0][2:0]));
    idle(1);
    chk("R9 zero mask clears line", 32'(cpu_irq), 32'h0);

    // R6 no latching: source falls, line falls
    mask_m = 32'h1; wr(3'd0, 32'h1);
    idle(1);
    chk("R6 line back on", 32'(cpu_irq), 32'(8'(1) << fld[0][2:0]));
    src_m = 32'h0;
    idle(3);
    chk("R6 line falls with source", 32'(cpu_irq), 32'h0);

    // R5 / R6 sweep of every source onto every line, bit 3 toggled
    src_m = 32'hFFFF_FFFF;
    idle(3);
    for (int n = 0; n < NS; n++) begin
      for (int k = 0; k < 8; k++) begin
        fld[n] = 4'(k | ((((n + k) & 1) != 0) ? 8 : 0));
        wr(3'(5 - n/8), route_word(5 - n/8));
        mask_m = 32'h1 << n;
        wr(3'd0, mask_m);
        idle(1);
        chk("R5 single source steered by low bits", 32'(cpu_irq), 32'(8'(1) << k));
      end
    end

    // R6 pseudo-random mixes
    seed = 32'h1F2E_3D4C;
    for (int it = 0; it < 24; it++) begin
      for (int n = 0; n < NS; n++) begin
        seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
        fld[n] = seed[7:4];
      end
      push_routes();
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      mask_m = seed;
      wr(3'd0, mask_m);
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      src_m = seed & seed[31:0] >> (it % 3);
      idle(4);
      chk("R6 random mix lines", 32'(cpu_irq), 32'(exp_out()));
      rd(3'd1, d); chk("R3 random mix status", d, src_m);
    end

    // R9 final disable
    mask_m = 32'h0;
    wr(3'd0, 32'h0);
    idle(1);
    chk("R9 mask cleared, all lines low", 32'(cpu_irq), 32'h0);

    finish_run();
  end
endmodule